// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames into host memory under control of a ring of descriptors. Each descriptor occupies two 32-bit words. The first word holds the status and a length. The second word holds the address of the frame buffer. The engine reads a descriptor and checks that the host has handed it to the device. It then stores the incoming frame bytes one at a time at that buffer address. When the frame ends, it writes the status word back with the received length and with the ownership flag cleared, which returns the descriptor to the host.

There is no ring-size register. The host closes the ring by setting an end-of-ring flag in its last descriptor. When the engine finishes that descriptor, its next fetch is from the ring base pointer again. A descriptor may carry an interrupt-request flag. When it does, the engine raises a one-cycle completion strobe for a downstream interrupt-coalescing block. The base pointer and the start command only take effect while the engine is idle. A stop request lets the current frame finish before the engine parks.

The memory port is 32 bits wide and uses a request/grant handshake. A request is held until it is granted. Read data arrives on the cycle after the grant.

Top module: `rxdma_ring_engine`

## Requirements
- R1: After reset the engine is idle: `idle_o`=1, `mem_req_o`=0, `rx_ready_o`=0 and `done_o`=0.
- R2: The status word is read from the descriptor address and the buffer address from descriptor address + 4. Frame byte k is written to buffer address + k. It goes to the aligned word address with exactly one byte-enable bit set, the bit for lane (address mod 4), and the byte is replicated across the write data.
- R3: The engine uses a descriptor only while bit 31 of its status word is set. If that bit is clear, the engine makes no writes and accepts no frame bytes. It keeps re-reading the same descriptor and never moves on to the next one.
- R4: On frame end the status word is written back with bit 31 = 0 and bit 30 = 1 (end of packet). Bits 29..25 and 23..16 keep the values that were fetched. Bits 15..0 hold the number of bytes stored.
- R5: The buffer size is bits 15..0 of the fetched status. Bytes beyond that size are still accepted, but they are discarded. When any byte is discarded, bit 24 of the written-back status is set. A size of 0 stores nothing.
- R6: After a write-back, the next descriptor is at the current descriptor address + 8. If bit 29 (end of ring) was set in the current descriptor, the next descriptor is at the ring base instead.
- R7: `done_o` pulses for exactly one cycle, in the cycle after the status write-back is granted, and only when bit 28 of the descriptor was set.
- R8: `ring_base_we_i` and `start_i` are obeyed only while idle. Start begins fetching at the stored base. If the base is written in the same cycle as start, fetching begins at the new base.
- R9: A stop request is honoured at the next descriptor boundary, or at once if the engine is polling a descriptor it does not own. The engine then returns to idle without dropping the frame in progress.
- R10: A memory request keeps its address and data until it is granted. Read data is taken on the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | AW | Ring base address value |
| ring_base_we_i | input | 1 | Load ring base (idle only) |
| start_i | input | 1 | Start command (idle only) |
| stop_i | input | 1 | Stop request |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_ready_o | output | 1 | Frame byte accepted this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request granted |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read grant |
| done_o | output | 1 | Completion strobe for descriptors that request it |
| idle_o | output | 1 | Engine stopped |

## Verification
The hardest behaviours to provoke are three. One is the ownership stall, where the engine must hold on an unowned descriptor while a later one is already owned. Another is the wrap that goes back to the ring base. The third is a base write that arrives while the engine is running and must be ignored. The stimulus starts the engine on an all-clear ring and marks only the second descriptor as owned. It then writes a bogus base while the engine is running. A bogus base that was wrongly accepted would send the fetch after the wrap into a clear descriptor. Throughout the run, grants are withheld on every fourth cycle so that requests have to be held.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_W     = $clog2(LANES);
    localparam int DESC_BYTES = 8;

    // status word bit positions
    localparam int BIT_OWN   = 31;
    localparam int BIT_EOP   = 30;
    localparam int BIT_EOR   = 29;
    localparam int BIT_IRQ   = 28;
    localparam int BIT_TRUNC = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_WT_STAT,
        ST_RD_ADDR,
        ST_WT_ADDR,
        ST_RECV,
        ST_WBACK
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_STAT,
        SEL_ADDR,
        SEL_BYTE,
        SEL_WB
    } mem_sel_e;

endpackage

// File: rtl/rxdma_lane_fmt.sv
module rxdma_lane_fmt
    import rxdma_pkg::*;
(
    input  logic [LANE_W-1:0] lane_i,
    input  logic [7:0]        byte_i,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] wdata_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_o[g]            = (lane_i == LANE_W'(g));
        assign wdata_o[8*g +: 8]  = byte_i;
    end

endmodule

// File: rtl/rxdma_wb_fmt.sv
module rxdma_wb_fmt
    import rxdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [WORD_W-1:0] stat_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              trunc_i,
    output logic [WORD_W-1:0] wb_o
);

    always_comb begin
        wb_o                 = stat_i;
        wb_o[BIT_OWN]        = 1'b0;
        wb_o[BIT_EOP]        = 1'b1;
        wb_o[BIT_TRUNC]      = trunc_i;
        wb_o[LEN_W-1:0]      = len_i;
    end

endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
    import rxdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base_i,
    input  logic              base_we_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rx_valid_i,
    input  logic              rx_last_i,
    input  logic              gnt_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              req_o,
    output logic              we_o,
    output mem_sel_e          sel_o,
    output logic              rx_ready_o,
    output rx_state_e         state_o,
    output logic [AW-1:0]     cur_o,
    output logic [AW-1:0]     bufa_o,
    output logic [LEN_W-1:0]  cnt_o,
    output logic [WORD_W-1:0] stat_o,
    output logic              trunc_o,
    output logic              done_o,
    output logic              idle_o
);

    localparam logic [AW-1:0]    STEP = AW'(DESC_BYTES);
    localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

    typedef struct packed {
        rx_state_e          st;
        logic [AW-1:0]      base;
        logic [AW-1:0]      cur;
        logic [WORD_W-1:0]  stat;
        logic [AW-1:0]      bufa;
        logic [LEN_W-1:0]   cnt;
        logic               trunc;
        logic               stop_pend;
        logic               done;
    } regs_t;

    regs_t r_q, r_d;
    logic  stop_now_d;
    logic  room_d;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        stop_now_d = r_q.stop_pend | stop_i;
        room_d     = r_q.cnt < r_q.stat[LEN_W-1:0];
        req_o      = 1'b0;
        we_o       = 1'b0;
        sel_o      = SEL_STAT;
        rx_ready_o = 1'b0;

        if (r_q.st != ST_IDLE && stop_i) begin
            r_d.stop_pend = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                r_d.stop_pend = 1'b0;
                if (base_we_i) begin
                    r_d.base = base_i;
                end
                if (start_i) begin
                    r_d.cur = base_we_i ? base_i : r_q.base;
                    r_d.st  = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                sel_o = SEL_STAT;
                if (stop_now_d) begin
                    r_d.st = ST_IDLE;
                end else begin
                    req_o = 1'b1;
                    if (gnt_i) begin
                        r_d.st = ST_WT_STAT;
                    end
                end
            end
            ST_WT_STAT: begin
                r_d.stat = rdata_i;
                // an unowned descriptor is polled again, never skipped
                r_d.st   = rdata_i[BIT_OWN] ? ST_RD_ADDR : ST_RD_STAT;
            end
            ST_RD_ADDR: begin
                sel_o = SEL_ADDR;
                req_o = 1'b1;
                if (gnt_i) begin
                    r_d.st = ST_WT_ADDR;
                end
            end
            ST_WT_ADDR: begin
                r_d.bufa  = rdata_i[AW-1:0];
                r_d.cnt   = '0;
                r_d.trunc = 1'b0;
                r_d.st    = ST_RECV;
            end
            ST_RECV: begin
                sel_o = SEL_BYTE;
                we_o  = 1'b1;
                if (rx_valid_i) begin
                    if (room_d) begin
                        req_o      = 1'b1;
                        rx_ready_o = gnt_i;
                        if (gnt_i) begin
                            r_d.cnt = r_q.cnt + ONE;
                            if (rx_last_i) begin
                                r_d.st = ST_WBACK;
                            end
                        end
                    end else begin
                        rx_ready_o = 1'b1;
                        r_d.trunc  = 1'b1;
                        if (rx_last_i) begin
                            r_d.st = ST_WBACK;
                        end
                    end
                end
            end
            ST_WBACK: begin
                sel_o = SEL_WB;
                we_o  = 1'b1;
                req_o = 1'b1;
                if (gnt_i) begin
                    r_d.done = r_q.stat[BIT_IRQ];
                    r_d.cur  = r_q.stat[BIT_EOR] ? r_q.base : r_q.cur + STEP;
                    r_d.st   = stop_now_d ? ST_IDLE : ST_RD_STAT;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign cur_o   = r_q.cur;
    assign bufa_o  = r_q.bufa;
    assign cnt_o   = r_q.cnt;
    assign stat_o  = r_q.stat;
    assign trunc_o = r_q.trunc;
    assign done_o  = r_q.done;
    assign idle_o  = (r_q.st == ST_IDLE);

endmodule

// File: rtl/rxdma_ring_engine.sv
module rxdma_ring_engine
    import rxdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ring_base_i,
    input  logic              ring_base_we_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_last_i,
    output logic              rx_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              done_o,
    output logic              idle_o
);

    localparam logic [AW-1:0] ADDR_OFS = AW'(WORD_W / 8);

    mem_sel_e          sel;
    rx_state_e         fsm_state;
    logic [AW-1:0]     fsm_cur;
    logic [AW-1:0]     bufa;
    logic [LEN_W-1:0]  cnt;
    logic [WORD_W-1:0] stat;
    logic              trunc;
    logic [AW-1:0]     byte_addr;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] wb_word;
    logic [AW-1:0]     raw_addr;

    rxdma_fsm #(.AW(AW), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_i     (ring_base_i),
        .base_we_i  (ring_base_we_i),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .rx_valid_i (rx_valid_i),
        .rx_last_i  (rx_last_i),
        .gnt_i      (mem_gnt_i),
        .rdata_i    (mem_rdata_i),
        .req_o      (mem_req_o),
        .we_o       (mem_we_o),
        .sel_o      (sel),
        .rx_ready_o (rx_ready_o),
        .state_o    (fsm_state),
        .cur_o      (fsm_cur),
        .bufa_o     (bufa),
        .cnt_o      (cnt),
        .stat_o     (stat),
        .trunc_o    (trunc),
        .done_o     (done_o),
        .idle_o     (idle_o)
    );

    assign byte_addr = bufa + AW'(cnt);

    rxdma_lane_fmt u_lane (
        .lane_i  (byte_addr[LANE_W-1:0]),
        .byte_i  (rx_data_i),
        .be_o    (lane_be),
        .wdata_o (lane_wdata)
    );

    rxdma_wb_fmt #(.LEN_W(LEN_W)) u_wb (
        .stat_i  (stat),
        .len_i   (cnt),
        .trunc_i (trunc),
        .wb_o    (wb_word)
    );

    always_comb begin
        raw_addr    = fsm_cur;
        mem_be_o    = '1;
        mem_wdata_o = wb_word;
        case (sel)
            SEL_STAT: raw_addr = fsm_cur;
            SEL_ADDR: raw_addr = fsm_cur + ADDR_OFS;
            SEL_BYTE: begin
                raw_addr    = byte_addr;
                mem_be_o    = lane_be;
                mem_wdata_o = lane_wdata;
            end
            default:  raw_addr = fsm_cur;
        endcase
        mem_addr_o = {raw_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
    end

endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker
    import rxdma_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idle_o,
    input logic          rx_ready_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_gnt_i,
    input logic [3:0]    mem_be_o,
    input logic [31:0]   mem_wdata_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_rdata_i,
    input logic          done_o,
    input rx_state_e     st,
    input logic [AW-1:0] cur
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!mem_req_o && !rx_ready_o));

    a_r2_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_be_o != 4'hF) |-> ($countones(mem_be_o) == 1));

    a_r3_repoll_same: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WT_STAT && !mem_rdata_i[31]) |=>
        ((st == ST_RD_STAT || st == ST_IDLE) && $stable(cur)));

    a_r4_owner_handback: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_be_o == 4'hF) |-> (!mem_wdata_o[31] && mem_wdata_o[30]));

    a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req_o && mem_gnt_i && mem_we_o &&
                         mem_be_o == 4'hF && mem_wdata_o[28]));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_be_o == 4'hF && !mem_gnt_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

endmodule

bind rxdma_ring_engine rxdma_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_o      (idle_o),
    .rx_ready_o  (rx_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .st          (fsm_state),
    .cur         (fsm_cur)
);

// File: tb/tb_rxdma_ring_engine.sv
`timescale 1ns/1ps
module tb_rxdma_ring_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = '0;
    logic        base_we = 1'b0, start = 1'b0, stop = 1'b0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, mem_req, mem_we, mem_gnt, done, idle;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    rxdma_ring_engine dut (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base), .ring_base_we_i(base_we),
        .start_i(start), .stop_i(stop), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_last_i(rx_last), .rx_ready_o(rx_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .done_o(done), .idle_o(idle)
    );

    // memory model: 256 words, grant withheld every fourth cycle
    logic [31:0] mem [256];
    logic [1:0]  gcnt = '0;
    logic        init_mem = 1'b0, host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_data = '0;
    int          wr_cnt = 0, done_cnt = 0;

    assign mem_gnt = (gcnt != 2'b11);
    always @(negedge clk) gcnt <= gcnt + 2'd1;

    always @(posedge clk) begin
        if (init_mem) begin
            for (int i = 0; i < 256; i++)
                mem[i] <= (i < 8 || (i >= 64 && i < 72)) ? 32'h0 : 32'hEEEEEEEE;
        end else begin
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                end
            end
            if (host_we) mem[host_addr[9:2]] <= host_data;
        end
        if (rst_n && done) done_cnt <= done_cnt + 1;
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input int a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 10'(a); host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic send_frame(input int len, input int seed);
        int k = 0;
        while (k < len) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + k);
            rx_last  = (k == len - 1);
            #1;
            if (rx_ready) k++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_owned_clear(input int a, output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 3000 && !ok; t++) begin
            @(negedge clk);
            if (!mem[a[9:2]][31]) ok = 1'b1;
        end
    endtask

    // {exp_trunc, exp_len[7:0], eor, irq, flen[7:0], bsz[7:0], bufaddr[15:0]}
    localparam logic [42:0] VEC [6] = '{
        {1'b0, 8'd5,  1'b0, 1'b1, 8'd5,  8'd16, 16'h0202},
        {1'b1, 8'd8,  1'b0, 1'b0, 8'd12, 8'd8,  16'h0240},
        {1'b0, 8'd32, 1'b1, 1'b1, 8'd32, 8'd32, 16'h0281},
        {1'b0, 8'd4,  1'b0, 1'b1, 8'd4,  8'd4,  16'h02C0},
        {1'b1, 8'd0,  1'b0, 1'b1, 8'd3,  8'd0,  16'h0300},
        {1'b0, 8'd1,  1'b1, 1'b0, 8'd1,  8'd20, 16'h0343}
    };

    task automatic run_desc(input int dsc, input int bufa, input int bsz, input int flen,
                            input bit irq, input bit eor, input int elen, input bit etr,
                            input int seed, input int exp_done);
        logic [31:0] st, expw;
        bit ok;
        int mism = 0;
        st = {1'b1, 1'b0, eor, irq, 3'b000, 1'b0, 8'h5A, 16'(bsz)};
        expw = {1'b0, 1'b1, eor, irq, 3'b000, etr, 8'h5A, 16'(elen)};
        host_write(dsc + 4, 32'(bufa));
        host_write(dsc, st);
        send_frame(flen, seed);
        wait_owned_clear(dsc, ok);
        check(ok, "R6 R3 descriptor at expected ring slot completed", 32'(ok), 32'd1);
        @(negedge clk); @(negedge clk);
        check(mem[dsc >> 2] == expw, "R4 R5 written-back status", mem[dsc >> 2], expw);
        for (int k = 0; k < elen; k++)
            if (rdb(bufa + k) != 8'(seed + k)) mism++;
        check(mism == 0, "R2 R10 stored bytes mismatches", 32'(mism), 32'd0);
        check(rdb(bufa + elen) == 8'hEE, "R5 byte past stored length untouched",
              32'(rdb(bufa + elen)), 32'hEE);
        check(done_cnt == exp_done, "R7 completion strobe count", 32'(done_cnt), 32'(exp_done));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int exp_done = 0;
        bit ok;
        init_mem = 1'b1;
        repeat (3) @(negedge clk);
        init_mem = 1'b0;
        #1;
        check(idle == 1'b1, "R1 idle in reset", 32'(idle), 32'd1);
        check(mem_req == 1'b0, "R1 no request in reset", 32'(mem_req), 32'd0);
        check(done == 1'b0 && rx_ready == 1'b0, "R1 done and ready low", 32'({done, rx_ready}), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R8: load base 0x100 and start
        @(negedge clk); ring_base = 32'h100; base_we = 1'b1;
        @(negedge clk); base_we = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(idle == 1'b0, "R8 engine running after start", 32'(idle), 32'd0);

        // R3: descriptor 0 unowned, descriptor 1 owned -> no skip
        host_write(32'h10C, 32'h0000_0200);
        host_write(32'h108, 32'h8000_0010);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h11; rx_last = 1'b0;
        repeat (30) begin
            @(negedge clk);
            #1;
            if (rx_ready) ok = 1'b0;
        end
        #1;
        check(rx_ready == 1'b0, "R3 no byte accepted while unowned", 32'(rx_ready), 32'd0);
        check(wr_cnt == 0, "R3 no writes while polling unowned descriptor", 32'(wr_cnt), 32'd0);
        @(negedge clk); rx_valid = 1'b0;
        host_write(32'h108, 32'h0);

        // R8: base write while running must be ignored (wrap test in row 3)
        @(negedge clk); ring_base = 32'h000; base_we = 1'b1;
        @(negedge clk); base_we = 1'b0;

        for (int r = 0; r < 6; r++) begin
            if (VEC[r][32]) exp_done++;
            run_desc(32'h100 + 8 * (r % 3), int'(VEC[r][15:0]), int'(VEC[r][23:16]),
                     int'(VEC[r][31:24]), VEC[r][32], VEC[r][33], int'(VEC[r][41:34]),
                     VEC[r][42], r * 16, exp_done);
        end

        // R9: stop while polling an unowned descriptor
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (8) @(negedge clk);
        check(idle == 1'b1, "R9 idle after stop", 32'(idle), 32'd1);
        check(mem_req == 1'b0, "R9 no requests after stop", 32'(mem_req), 32'd0);

        // R8: new base taken while idle, start fetches from it
        @(negedge clk); ring_base = 32'h000; base_we = 1'b1;
        @(negedge clk); base_we = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        exp_done++;
        run_desc(32'h000, 32'h380, 8, 3, 1'b1, 1'b1, 3, 1'b0, 8'hA0, exp_done);
        check(idle == 1'b0, "R8 running from new base", 32'(idle), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule